// File: doc/BRIEF.md
# Speculative Cache Line State Tracker

This block holds the per-line state of a small direct-mapped data cache that belongs to one core running speculative threads. Each line has a valid bit, a tag, a data word and two speculation flags: one records that the running thread read the line speculatively, the other that it wrote the line speculatively. Core requests arrive on a valid/ready stream and are answered on a second valid/ready stream. A request is a load, a store or a line fill, and a load or store can be marked speculative. The fill op stands in for the refill path, which lies outside this block.

Other cores broadcast their stores as invalidations on a snoop input. Each invalidation carries the store address and the storing thread's epoch. The block compares that epoch with the local epoch. It raises a sticky violation when a logically earlier thread wrote a line this thread has already read speculatively. A squash pulse throws away all speculative writes in one cycle. A commit pulse makes them permanent in one cycle.

Back-pressure: a request transfers in a cycle where `req_valid` and `req_ready` are both high. The answer appears on the response stream in the next cycle and stays unchanged until `rsp_ready` is high. `req_ready` is low while a response is waiting unread, and also while a violation is pending or in any cycle where `snp_valid`, `squash` or `commit` is high.

Top module: `spec_line_tracker`

## Requirements
- R1: A load whose address hits a valid line answers status 1 (done) with that line's data, and a miss answers status 0 (miss). A load hit marked speculative sets the line's speculatively-read flag. The index is the low log2(LINES) address bits and the tag is the remaining upper bits.
- R2: A speculative store that hits writes the data, answers status 1 and sets the line's speculatively-written flag. A speculative store that misses answers status 2 (stall) and changes nothing.
- R3: A squash makes every line with the speculatively-written flag invalid within one cycle, clears both flags on all lines and clears the violation. Lines without that flag keep their valid bit and data.
- R4: A commit clears both flags on all lines in one cycle, and lines written speculatively keep their new data. A commit is ignored while the violation is asserted. A squash in the same cycle takes priority over a commit.
- R5: A snoop that hits a valid line whose speculatively-read flag is set raises the violation in the following cycle when the snoop epoch is numerically lower than the local epoch.
- R6: A snoop from an equal or higher epoch never raises the violation. It invalidates the hit line only if neither flag is set, and otherwise it leaves the line unchanged.
- R7: Once raised, the violation stays high until a squash. While it is high, `req_ready` is low and no request is accepted.
- R8: A non-speculative store that hits is performed (status 1) only if the speculatively-written flag is clear, and it sets no flag. Otherwise it answers status 2. A non-speculative store that misses allocates the line (status 1) unless the indexed line has either flag set, in which case it answers status 2.
- R9: A fill (op 2) installs tag and data as a clean valid line (status 1) unless the indexed line has either flag set, in which case it answers status 2 and leaves the line alone. Op 0 is load and op 1 is store.
- R10: The 4-bit unsigned local epoch is loaded from `cfg_epoch` in any cycle where `cfg_epoch_we` is high, and it is reset to 0.
- R11: An accepted request is answered with `rsp_valid` high one cycle later. The answer is held stable while `rsp_ready` is low. `req_ready` is low while a response waits unread or while `snp_valid`, `squash` or `commit` is high.
- R12: A snoop from a lower epoch that hits a line with neither flag set invalidates it. A snoop from a lower epoch that hits a line with only the speculatively-written flag set leaves the line unchanged and raises no violation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_epoch_we | input | 1 | Loads the local epoch |
| cfg_epoch | input | 4 | Local thread epoch value |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted this cycle if valid |
| req_op | input | 2 | 0 load, 1 store, 2 fill |
| req_spec | input | 1 | Request is speculative |
| req_addr | input | 8 | Word address |
| req_wdata | input | 16 | Store or fill data |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_status | output | 2 | 0 miss, 1 done, 2 stall |
| rsp_rdata | output | 16 | Load data on a done load, else zero |
| snp_valid | input | 1 | Snooped invalidation present |
| snp_addr | input | 8 | Invalidated word address |
| snp_epoch | input | 4 | Epoch of the storing thread |
| squash | input | 1 | Discard speculative state |
| commit | input | 1 | Make speculative state permanent |
| violation | output | 1 | Sticky dependence violation |

## Verification
The bench targets snoops exactly at the epoch boundary, where equal epochs must stay silent. A swapped comparison would raise false violations or miss real ones. It also targets snoops onto lines carrying only the written flag. A tracker that invalidated those lines would lose speculative data, and one that flagged them would squash needlessly. After a squash the bench checks that read-only lines survive while written lines vanish. A design that dropped every line would turn later loads into misses. Commits issued during a pending violation, stores into written lines and fills over flagged lines are all checked. A design that let any of these through would leak or destroy speculative state.

// File: rtl/spec_cache_pkg.sv
`timescale 1ns/1ps
package spec_cache_pkg;
  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FILL  = 2'd2,
    OP_RSVD  = 2'd3
  } req_op_e;

  typedef enum logic [1:0] {
    ST_MISS  = 2'd0,
    ST_DONE  = 2'd1,
    ST_STALL = 2'd2,
    ST_RSVD  = 2'd3
  } rsp_st_e;

  typedef enum logic [1:0] {
    SNP_IGNORE  = 2'd0,
    SNP_KILL    = 2'd1,
    SNP_VIOLATE = 2'd2
  } snp_act_e;
endpackage

// File: rtl/sc_req_decode.sv
`timescale 1ns/1ps
module sc_req_decode
  import spec_cache_pkg::*;
(
  input  logic [1:0] op_i,
  input  logic       spec_i,
  input  logic       hit_i,
  input  logic       line_sl_i,
  input  logic       line_sm_i,
  output rsp_st_e    status_o,
  output logic       wr_data_o,
  output logic       install_o,
  output logic       set_sl_o,
  output logic       set_sm_o
);
  logic flagged;
  assign flagged = line_sl_i | line_sm_i;

  always_comb begin
    status_o  = ST_MISS;
    wr_data_o = 1'b0;
    install_o = 1'b0;
    set_sl_o  = 1'b0;
    set_sm_o  = 1'b0;
    case (req_op_e'(op_i))
      OP_LOAD: begin
        if (hit_i) begin
          status_o = ST_DONE;
          set_sl_o = spec_i;
        end
      end
      OP_STORE: begin
        if (spec_i) begin
          if (hit_i) begin
            status_o  = ST_DONE;
            wr_data_o = 1'b1;
            set_sm_o  = 1'b1;
          end else begin
            status_o = ST_STALL;
          end
        end else if (hit_i) begin
          if (!line_sm_i) begin
            status_o  = ST_DONE;
            wr_data_o = 1'b1;
          end else begin
            status_o = ST_STALL;
          end
        end else if (flagged) begin
          status_o = ST_STALL;
        end else begin
          status_o  = ST_DONE;
          install_o = 1'b1;
          wr_data_o = 1'b1;
        end
      end
      OP_FILL: begin
        if (flagged) begin
          status_o = ST_STALL;
        end else begin
          status_o  = ST_DONE;
          install_o = 1'b1;
          wr_data_o = 1'b1;
        end
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/sc_snoop_judge.sv
`timescale 1ns/1ps
module sc_snoop_judge
  import spec_cache_pkg::*;
#(
  parameter int EPOCH_W = 4
) (
  input  logic               hit_i,
  input  logic               line_sl_i,
  input  logic               line_sm_i,
  input  logic [EPOCH_W-1:0] snp_epoch_i,
  input  logic [EPOCH_W-1:0] own_epoch_i,
  output snp_act_e           act_o
);
  logic earlier;
  assign earlier = snp_epoch_i < own_epoch_i;

  always_comb begin
    act_o = SNP_IGNORE;
    if (hit_i) begin
      if (line_sl_i && earlier)           act_o = SNP_VIOLATE;
      else if (!line_sl_i && !line_sm_i)  act_o = SNP_KILL;
    end
  end
endmodule

// File: rtl/sc_line_store.sv
`timescale 1ns/1ps
module sc_line_store #(
  parameter int LINES  = 8,
  parameter int TAG_W  = 5,
  parameter int DATA_W = 16,
  localparam int IDX_W = $clog2(LINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              squash_i,
  input  logic              commit_i,
  input  logic              kill_en_i,
  input  logic [IDX_W-1:0]  kill_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic              wr_install_i,
  input  logic              wr_data_en_i,
  input  logic              wr_set_sl_i,
  input  logic              wr_set_sm_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [LINES-1:0]  valid_o,
  output logic [LINES-1:0]  sl_o,
  output logic [LINES-1:0]  sm_o,
  output logic [TAG_W-1:0]  tag_o  [LINES],
  output logic [DATA_W-1:0] data_o [LINES]
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic              v_q, sl_q, sm_q;
    logic [TAG_W-1:0]  tag_q;
    logic [DATA_W-1:0] data_q;
    logic              sel_wr, sel_kill;

    assign sel_wr   = wr_en_i   && (wr_idx_i   == IDX_W'(g));
    assign sel_kill = kill_en_i && (kill_idx_i == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        v_q    <= 1'b0;
        sl_q   <= 1'b0;
        sm_q   <= 1'b0;
        tag_q  <= '0;
        data_q <= '0;
      end else if (squash_i) begin
        if (sm_q) v_q <= 1'b0;
        sl_q <= 1'b0;
        sm_q <= 1'b0;
      end else if (commit_i) begin
        sl_q <= 1'b0;
        sm_q <= 1'b0;
      end else if (sel_kill) begin
        v_q <= 1'b0;
      end else if (sel_wr) begin
        if (wr_install_i) begin
          v_q   <= 1'b1;
          tag_q <= wr_tag_i;
          sl_q  <= 1'b0;
          sm_q  <= 1'b0;
        end
        if (wr_data_en_i) data_q <= wr_data_i;
        if (wr_set_sl_i)  sl_q   <= 1'b1;
        if (wr_set_sm_i)  sm_q   <= 1'b1;
      end
    end

    assign valid_o[g] = v_q;
    assign sl_o[g]    = sl_q;
    assign sm_o[g]    = sm_q;
    assign tag_o[g]   = tag_q;
    assign data_o[g]  = data_q;

    AST_SQUASH_KEEPS_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
      squash_i && v_q && !sm_q |=> v_q && $stable(data_q)); // R3
    AST_SQUASH_DROPS_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
      squash_i && sm_q |=> !v_q); // R3
    AST_COMMIT_KEEPS_SPEC: assert property (@(posedge clk) disable iff (!rst_n)
      commit_i && !squash_i && v_q |=> v_q && !sl_q && !sm_q); // R4
  end

  AST_FLASH_CLEARS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    squash_i || commit_i |=> $countones({sl_o, sm_o}) == 0); // R3
endmodule

// File: rtl/spec_line_tracker.sv
`timescale 1ns/1ps
module spec_line_tracker
  import spec_cache_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int DATA_W  = 16,
  parameter int LINES   = 8,
  parameter int EPOCH_W = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_epoch_we,
  input  logic [EPOCH_W-1:0] cfg_epoch,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [1:0]         req_op,
  input  logic               req_spec,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [1:0]         rsp_status,
  output logic [DATA_W-1:0]  rsp_rdata,
  input  logic               snp_valid,
  input  logic [ADDR_W-1:0]  snp_addr,
  input  logic [EPOCH_W-1:0] snp_epoch,
  input  logic               squash,
  input  logic               commit,
  output logic               violation
);
  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [LINES-1:0]  valid_v, sl_v, sm_v;
  logic [TAG_W-1:0]  tag_a  [LINES];
  logic [DATA_W-1:0] data_a [LINES];

  logic [EPOCH_W-1:0] epoch_q;
  logic               viol_q;
  logic               rsp_valid_q;
  logic [1:0]         rsp_status_q;
  logic [DATA_W-1:0]  rsp_rdata_q;

  // request path lookup
  logic [IDX_W-1:0] r_idx;
  logic [TAG_W-1:0] r_tag;
  logic             r_hit;
  assign r_idx = req_addr[IDX_W-1:0];
  assign r_tag = req_addr[ADDR_W-1:IDX_W];
  assign r_hit = valid_v[r_idx] && (tag_a[r_idx] == r_tag);

  rsp_st_e r_status;
  logic    r_wr_data, r_install, r_set_sl, r_set_sm;

  sc_req_decode u_decode (
    .op_i      (req_op),
    .spec_i    (req_spec),
    .hit_i     (r_hit),
    .line_sl_i (sl_v[r_idx]),
    .line_sm_i (sm_v[r_idx]),
    .status_o  (r_status),
    .wr_data_o (r_wr_data),
    .install_o (r_install),
    .set_sl_o  (r_set_sl),
    .set_sm_o  (r_set_sm)
  );

  // snoop path lookup
  logic [IDX_W-1:0] s_idx;
  logic [TAG_W-1:0] s_tag;
  logic             s_hit;
  snp_act_e         s_act;
  assign s_idx = snp_addr[IDX_W-1:0];
  assign s_tag = snp_addr[ADDR_W-1:IDX_W];
  assign s_hit = valid_v[s_idx] && (tag_a[s_idx] == s_tag);

  sc_snoop_judge #(.EPOCH_W(EPOCH_W)) u_judge (
    .hit_i       (s_hit),
    .line_sl_i   (sl_v[s_idx]),
    .line_sm_i   (sm_v[s_idx]),
    .snp_epoch_i (snp_epoch),
    .own_epoch_i (epoch_q),
    .act_o       (s_act)
  );

  // control arbitration: squash > commit > snoop > request
  logic busy, commit_eff, snp_eff, req_fire;
  assign busy       = squash || commit;
  assign commit_eff = commit && !squash && !viol_q;
  assign snp_eff    = snp_valid && !busy;
  assign req_ready  = !viol_q && !busy && !snp_valid && (!rsp_valid_q || rsp_ready);
  assign req_fire   = req_valid && req_ready;

  sc_line_store #(.LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk          (clk),
    .rst_n        (rst_n),
    .squash_i     (squash),
    .commit_i     (commit_eff),
    .kill_en_i    (snp_eff && (s_act == SNP_KILL)),
    .kill_idx_i   (s_idx),
    .wr_en_i      (req_fire),
    .wr_idx_i     (r_idx),
    .wr_install_i (r_install),
    .wr_data_en_i (r_wr_data),
    .wr_set_sl_i  (r_set_sl),
    .wr_set_sm_i  (r_set_sm),
    .wr_tag_i     (r_tag),
    .wr_data_i    (req_wdata),
    .valid_o      (valid_v),
    .sl_o         (sl_v),
    .sm_o         (sm_v),
    .tag_o        (tag_a),
    .data_o       (data_a)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            epoch_q <= '0;
    else if (cfg_epoch_we) epoch_q <= cfg_epoch;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                 viol_q <= 1'b0;
    else if (squash)                            viol_q <= 1'b0;
    else if (snp_eff && s_act == SNP_VIOLATE)   viol_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q  <= 1'b0;
      rsp_status_q <= '0;
      rsp_rdata_q  <= '0;
    end else if (req_fire) begin
      rsp_valid_q  <= 1'b1;
      rsp_status_q <= r_status;
      rsp_rdata_q  <= (r_status == ST_DONE && req_op == OP_LOAD) ? data_a[r_idx] : '0;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid  = rsp_valid_q;
  assign rsp_status = rsp_status_q;
  assign rsp_rdata  = rsp_rdata_q;
  assign violation  = viol_q;

  AST_VIOL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q && !squash |=> viol_q); // R7
  AST_NO_ACCEPT_IN_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    viol_q |-> !req_ready); // R7
  AST_SQUASH_CLEARS_VIOL: assert property (@(posedge clk) disable iff (!rst_n)
    squash |=> !viol_q); // R3
  AST_VIOL_FROM_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(viol_q) |-> $past(snp_valid) && !$past(squash)); // R5
  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid_q && !rsp_ready |=> rsp_valid_q && $stable(rsp_rdata_q) && $stable(rsp_status_q)); // R11
  AST_ACCEPT_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> rsp_valid_q); // R11
endmodule

// File: tb/spec_line_tracker_tb_top.sv
`timescale 1ns/1ps
module spec_line_tracker_tb_top;
  localparam int ADDR_W = 8, DATA_W = 16, LINES = 8, EPOCH_W = 4;
  localparam int IDX_W = 3, TAG_W = ADDR_W - IDX_W;
  localparam logic [1:0] LD = 2'd0, STO = 2'd1, FIL = 2'd2;
  localparam logic [1:0] S_MISS = 2'd0, S_DONE = 2'd1, S_STALL = 2'd2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_epoch_we = 1'b0;
  logic [EPOCH_W-1:0] cfg_epoch = '0;
  logic req_valid = 1'b0, req_spec = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_op = '0;
  logic [ADDR_W-1:0] req_addr = '0, snp_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0;
  logic snp_valid = 1'b0, squash = 1'b0, commit = 1'b0;
  logic [EPOCH_W-1:0] snp_epoch = '0;
  logic req_ready, rsp_valid, violation;
  logic [1:0] rsp_status;
  logic [DATA_W-1:0] rsp_rdata;

  always #2 clk = ~clk;

  spec_line_tracker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINES(LINES), .EPOCH_W(EPOCH_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_epoch_we(cfg_epoch_we), .cfg_epoch(cfg_epoch),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op), .req_spec(req_spec),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_status(rsp_status), .rsp_rdata(rsp_rdata), .snp_valid(snp_valid), .snp_addr(snp_addr),
    .snp_epoch(snp_epoch), .squash(squash), .commit(commit), .violation(violation));

  // reference model
  bit m_v [LINES];
  bit m_sl [LINES];
  bit m_sm [LINES];
  logic [TAG_W-1:0]  m_tag [LINES];
  logic [DATA_W-1:0] m_data [LINES];
  bit m_viol;
  logic [EPOCH_W-1:0] m_epoch;
  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic model_req(input logic [1:0] op, input bit spec, input logic [ADDR_W-1:0] a,
                           input logic [DATA_W-1:0] d, output logic [1:0] st, output logic [DATA_W-1:0] rd);
    int i = int'(a[IDX_W-1:0]);
    logic [TAG_W-1:0] t = a[ADDR_W-1:IDX_W];
    bit hit = m_v[i] && (m_tag[i] == t);
    bit fl = m_sl[i] || m_sm[i];
    st = S_MISS; rd = '0;
    if (op == LD) begin
      if (hit) begin st = S_DONE; rd = m_data[i]; if (spec) m_sl[i] = 1; end
    end else if (op == STO && spec) begin
      if (hit) begin st = S_DONE; m_data[i] = d; m_sm[i] = 1; end
      else st = S_STALL;
    end else if (op == STO && hit) begin
      if (!m_sm[i]) begin st = S_DONE; m_data[i] = d; end
      else st = S_STALL;
    end else begin
      if (fl) st = S_STALL;
      else begin st = S_DONE; m_v[i] = 1; m_tag[i] = t; m_data[i] = d; end
    end
  endtask

  task automatic do_req(input logic [1:0] op, input bit spec, input logic [ADDR_W-1:0] a,
                        input logic [DATA_W-1:0] d, input string rq);
    logic [1:0] st; logic [DATA_W-1:0] rd;
    @(negedge clk);
    req_valid = 1; req_op = op; req_spec = spec; req_addr = a; req_wdata = d;
    #1;
    if (m_viol) begin
      chk(req_ready == 1'b0, "R7 ready during violation", 32'(req_ready), 0);
      @(negedge clk); req_valid = 0;
    end else begin
      chk(req_ready == 1'b1, "R11 ready when idle", 32'(req_ready), 1);
      model_req(op, spec, a, d, st, rd);
      @(negedge clk); req_valid = 0;
      chk(rsp_valid == 1'b1, "R11 response one cycle later", 32'(rsp_valid), 1);
      chk(rsp_status == st, rq, 32'(rsp_status), 32'(st));
      if (op == LD && st == S_DONE) chk(rsp_rdata == rd, rq, 32'(rsp_rdata), 32'(rd));
    end
  endtask

  task automatic do_snoop(input logic [ADDR_W-1:0] a, input logic [EPOCH_W-1:0] e, input string rq);
    int i = int'(a[IDX_W-1:0]);
    @(negedge clk);
    snp_valid = 1; snp_addr = a; snp_epoch = e;
    #1;
    chk(req_ready == 1'b0, "R11 ready low during snoop", 32'(req_ready), 0);
    if (m_v[i] && m_tag[i] == a[ADDR_W-1:IDX_W]) begin
      if (m_sl[i] && e < m_epoch) m_viol = 1;
      else if (!m_sl[i] && !m_sm[i]) m_v[i] = 0;
    end
    @(negedge clk); snp_valid = 0;
    chk(violation == m_viol, rq, 32'(violation), 32'(m_viol));
  endtask

  task automatic do_squash();
    @(negedge clk); squash = 1;
    for (int i = 0; i < LINES; i++) begin
      if (m_sm[i]) m_v[i] = 0;
      m_sl[i] = 0; m_sm[i] = 0;
    end
    m_viol = 0;
    @(negedge clk); squash = 0;
    chk(violation == 1'b0, "R3 squash clears violation", 32'(violation), 0);
  endtask

  task automatic do_commit();
    @(negedge clk); commit = 1;
    if (!m_viol) for (int i = 0; i < LINES; i++) begin m_sl[i] = 0; m_sm[i] = 0; end
    @(negedge clk); commit = 0;
    chk(violation == m_viol, "R4 commit and violation", 32'(violation), 32'(m_viol));
  endtask

  task automatic set_epoch(input logic [EPOCH_W-1:0] e);
    @(negedge clk); cfg_epoch_we = 1; cfg_epoch = e; m_epoch = e;
    @(negedge clk); cfg_epoch_we = 0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] held;
    void'($urandom(32'd2024));
    for (int i = 0; i < LINES; i++) begin
      m_v[i] = 0; m_sl[i] = 0; m_sm[i] = 0; m_tag[i] = '0; m_data[i] = '0;
    end
    m_viol = 0; m_epoch = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(violation == 0, "R7 reset violation low", 32'(violation), 0);
    chk(rsp_valid == 0, "R11 reset no response", 32'(rsp_valid), 0);
    chk(req_ready == 1, "R11 reset ready", 32'(req_ready), 1);

    // directed corner cases
    do_req(LD, 0, 8'h0A, 0, "R1 load miss");
    do_req(FIL, 0, 8'h0A, 16'h1111, "R9 fill clean line");
    do_req(LD, 0, 8'h0A, 0, "R1 load hit data");
    set_epoch(4'd5);
    do_req(LD, 1, 8'h0A, 0, "R1 speculative load hit");
    do_snoop(8'h0A, 4'd5, "R6 equal epoch no violation");
    do_snoop(8'h0A, 4'd9, "R6 later epoch no violation");
    do_req(LD, 0, 8'h0A, 0, "R6 flagged line kept");
    do_req(FIL, 0, 8'h12, 16'h2222, "R9 fill over read-flagged line stalls");
    do_snoop(8'h0A, 4'd4, "R5 earlier epoch raises violation");
    do_req(LD, 0, 8'h0A, 0, "R7 blocked");
    do_commit();
    chk(violation == 1, "R4 commit ignored during violation", 32'(violation), 1);
    do_squash();
    do_req(LD, 0, 8'h0A, 0, "R3 read-only line survives squash");
    do_req(FIL, 0, 8'h0B, 16'h3333, "R9 fill second line");
    do_req(STO, 1, 8'h0B, 16'h4444, "R2 speculative store hit");
    do_req(LD, 0, 8'h0B, 0, "R2 speculative data visible");
    do_req(STO, 0, 8'h0B, 16'h5555, "R8 plain store to written line stalls");
    do_req(STO, 1, 8'h0C, 16'h6666, "R2 speculative store miss stalls");
    do_req(LD, 0, 8'h0C, 0, "R2 stalled store left no line");
    do_snoop(8'h0B, 4'd1, "R12 earlier epoch on write-only line ignored");
    do_req(LD, 0, 8'h0B, 0, "R12 write-only line unchanged");
    do_squash();
    do_req(LD, 0, 8'h0B, 0, "R3 written line gone after squash");
    do_req(FIL, 0, 8'h0B, 16'h7777, "R9 refill");
    do_req(STO, 1, 8'h0B, 16'h8888, "R2 speculative store again");
    do_commit();
    do_req(LD, 0, 8'h0B, 0, "R4 committed data kept");
    do_req(STO, 0, 8'h0B, 16'h9999, "R8 plain store after commit");
    do_req(STO, 0, 8'h1D, 16'hAAAA, "R8 plain store miss allocates");
    do_req(LD, 1, 8'h1D, 0, "R8 plain store set no flag");
    do_snoop(8'h0B, 4'd2, "R12 earlier epoch kills clean line");
    do_req(LD, 0, 8'h0B, 0, "R12 killed line misses");
    do_snoop(8'h1D, 4'd15, "R6 later epoch on read line ignored");
    set_epoch(4'd0);
    do_snoop(8'h1D, 4'd0, "R10 epoch zero never violates");
    do_squash();

    // response back-pressure
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_op = LD; req_spec = 0; req_addr = 8'h1D;
    @(negedge clk); req_valid = 0;
    held = rsp_rdata;
    chk(rsp_rdata == 16'hAAAA, "R1 load data before stall", 32'(rsp_rdata), 32'hAAAA);
    @(negedge clk);
    chk(rsp_valid == 1, "R11 response held", 32'(rsp_valid), 1);
    chk(rsp_rdata == held, "R11 response stable", 32'(rsp_rdata), 32'(held));
    chk(req_ready == 0, "R11 ready low while response waits", 32'(req_ready), 0);
    rsp_ready = 1;
    @(negedge clk);
    chk(rsp_valid == 0, "R11 response drained", 32'(rsp_valid), 0);

    // constrained random phase
    for (int n = 0; n < 3000; n++) begin
      int r = int'($urandom % 20);
      logic [ADDR_W-1:0] a = {5'($urandom % 3), 3'($urandom % LINES)};
      if (r < 11)       do_req(2'($urandom % 3), 1'($urandom), a, 16'($urandom), "R1 R2 R8 R9 random request");
      else if (r < 15)  do_snoop(a, 4'($urandom), "R5 R6 R12 random snoop");
      else if (r < 17)  do_squash();
      else if (r < 18)  do_commit();
      else if (r < 19)  set_epoch(4'($urandom));
      else              do_req(LD, 0, a, 0, "R1 random plain load");
    end

    summary();
    $finish;
  end
endmodule